// File: doc/BRIEF.md
# Sine-Cosine Unit with Register-Stack Push

The block evaluates sine and cosine of the top entry of an eight-entry operand stack in one operation. When it finishes, the sine replaces the old top entry and the cosine is pushed above it. The stack therefore grows by one, with the cosine as the new top and the sine directly beneath.

Operands use a compact tagged format. A two-bit class marks zero, finite, infinity or NaN, and finite values carry a sign, an exponent and a normalized mantissa. A finite operand whose magnitude is at most 2^63 is handled in four steps:
- It is reduced into one turn by an iterative doubling-and-subtract loop in fixed point.
- It is mapped to [-π, π].
- It is folded into [-π/2, π/2].
- It is rotated by a 16-step CORDIC engine.

A larger operand is rejected through a range flag, and the stack is left alone. Zero, infinity and NaN follow fixed class rules and finish in one cycle.

Operands enter through a valid/ready push port. `push_ready` is low while an operation runs, while `start` is high, and while the stack is full. A producer holds `push_valid` and `push_data` until it sees ready. The operation itself uses a plain `start` pulse, with no acknowledge. `busy` covers the run, and `done` is a one-cycle pulse. The three flags `c2`, `invalid_op` and `stk_err` describe the most recent completed operation.

Top module: `sincos_unit`

## Requirements
- R1: After a successful operation, `depth` has grown by one, `st0` holds the cosine and `st1` holds the sine.
- R2: Entry encoding is {class[26:25], sign[24], exponent[23:16] two's complement, mantissa[15:0] with bit 15 set}, value = mantissa·2^(exponent−15), class 0 zero, 1 finite, 2 infinity, 3 NaN. A finite operand with magnitude above 2^63 (exponent > 63, or exponent 63 with mantissa ≠ 0x8000) sets `c2`, and `depth` and `st0` stay unchanged. Exactly 2^63 is accepted.
- R3: Every completion that is not out of range clears `c2`, and an out-of-range operand leaves `invalid_op` low.
- R4: An operand of class zero yields a sine that is the same signed zero and a cosine of +1 (class 1, sign 0, exponent 0, mantissa 0x8000).
- R5: For a finite in-range operand, both results lie in [−1, +1], and for |x| < 16 each is within 2^−10 of the true value.
- R6: An infinite operand of either sign raises `invalid_op`, writes the default NaN (class 3, sign 1, exponent 0, mantissa 0xC000) as both results, and still pushes.
- R7: A NaN operand writes that same NaN as both sine and cosine, leaves `invalid_op` low, and pushes.
- R8: An operation that needs a push while the stack holds eight entries sets `stk_err` and leaves `depth` and `st0` unchanged.
- R9: `done` is high for exactly one cycle per operation, `busy` is high from the cycle after `start` until `done`, and a `start` while busy is ignored.
- R10: `push_ready` is high only when idle, with `start` low and fewer than eight entries. An accepted push raises `depth` by one and shows the pushed entry on `st0`.
- R11: A `start` on an empty stack sets `stk_err` and writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| push_valid | input | 1 | Operand push request |
| push_ready | output | 1 | Push accepted this cycle when high together with valid |
| push_data | input | 27 | Entry to push |
| start | input | 1 | One-cycle request to run the operation |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| depth | output | 4 | Number of stack entries |
| st0 | output | 27 | Top entry |
| st1 | output | 27 | Entry below the top |
| c2 | output | 1 | Last operand was out of range |
| invalid_op | output | 1 | Last operand was an invalid operand |
| stk_err | output | 1 | Last operation hit a full or empty stack |

## Verification
A wrong reduction count or a wrong fold decision corrupts only the value on `st0`/`st1`. That error appears at the `done` of the same operation, up to about 82 cycles after `start`, so the bench sweeps many angles across all four quadrants and compares against arithmetic references. A wrong stack pointer or a misrouted write shows at once in `depth` and in which of `st0`/`st1` holds which result. A stale flag shows at the next completion, so range rejections are followed directly by accepted operations. The boundary at exactly 2^63, the signed zeros, the specials, and full and empty stacks are each run on their own.

// File: rtl/scu_pkg.sv
package scu_pkg;
  typedef enum logic [1:0] {CL_ZERO = 2'd0, CL_FIN = 2'd1, CL_INF = 2'd2, CL_NAN = 2'd3} fcls_e;

  typedef struct packed {
    fcls_e             cls;
    logic              sgn;
    logic signed [7:0] exp;
    logic [15:0]       mant;
  } fpv_t;

  localparam int MW   = $bits(fpv_t);
  localparam int FRAC = 20;
  localparam int AW   = FRAC + 4;
  typedef logic signed [AW-1:0] fix_t;

  localparam fix_t K_GAIN = fix_t'(636751);
  localparam fix_t PI_F   = fix_t'(3294199);
  localparam fix_t HPI_F  = fix_t'(1647099);
  localparam fix_t TPI_F  = fix_t'(6588397);
  localparam fix_t ONE_F  = fix_t'(1048576);

  localparam fpv_t NAN_DEF = '{cls: CL_NAN, sgn: 1'b1, exp: 8'sd0, mant: 16'hC000};
  localparam fpv_t ONE_V   = '{cls: CL_FIN, sgn: 1'b0, exp: 8'sd0, mant: 16'h8000};

  function automatic fix_t atan_f(input int i);
    fix_t r;
    case (i)
      0: r = fix_t'(823550);
      1: r = fix_t'(486170);
      2: r = fix_t'(256878);
      3: r = fix_t'(130396);
      4: r = fix_t'(65452);
      5: r = fix_t'(32757);
      6: r = fix_t'(16383);
      7: r = fix_t'(8192);
      8: r = fix_t'(4096);
      default: r = (i <= FRAC) ? (fix_t'(1) <<< (FRAC - i)) : '0;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/scu_reduce.sv
module scu_reduce
  import scu_pkg::*;
#(
  parameter int MAXE = 63
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic              sgn,
  input  logic signed [7:0] exp,
  input  logic [15:0]       mant,
  output logic              done,
  output fix_t              angle,
  output logic              flip
);
  localparam int CW = $clog2(MAXE + 1);

  logic          busy, neg;
  logic [CW-1:0] cnt;
  logic [AW-1:0] r, base;
  logic [AW:0]   dbl;
  fix_t          a_fold;
  logic          fl;

  // starting residue: operand scaled to [1,2) or below when exponent <= 0
  always_comb begin
    int sh;
    sh   = -int'(exp);
    base = AW'(mant) << (FRAC - 15);
    if (exp < 8'sd0) base = (sh >= AW) ? '0 : (base >> sh);
  end

  // one doubling step of the residue modulo one turn
  always_comb begin
    dbl = {r, 1'b0};
    if (dbl >= (AW+1)'(TPI_F)) dbl = dbl - (AW+1)'(TPI_F);
  end

  // map to [-pi, pi], apply sign, fold into [-pi/2, pi/2]
  always_comb begin
    a_fold = fix_t'(r);
    if (a_fold > PI_F) a_fold = a_fold - TPI_F;
    if (neg) a_fold = -a_fold;
    fl = 1'b0;
    if (a_fold > HPI_F) begin
      a_fold = a_fold - PI_F;
      fl     = 1'b1;
    end else if (a_fold < -HPI_F) begin
      a_fold = a_fold + PI_F;
      fl     = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      done  <= 1'b0;
      neg   <= 1'b0;
      cnt   <= '0;
      r     <= '0;
      angle <= '0;
      flip  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (go) begin
        r    <= base;
        cnt  <= (exp > 8'sd0) ? CW'(exp) : '0;
        neg  <= sgn;
        busy <= 1'b1;
      end else if (busy) begin
        if (cnt != '0) begin
          r   <= dbl[AW-1:0];
          cnt <= cnt - 1'b1;
        end else begin
          busy  <= 1'b0;
          done  <= 1'b1;
          angle <= a_fold;
          flip  <= fl;
        end
      end
    end
  end

  AST_FOLDED_ANGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (angle <= HPI_F) && (angle >= -HPI_F)); // R5
endmodule

// File: rtl/scu_cordic.sv
module scu_cordic
  import scu_pkg::*;
#(
  parameter int ITERS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  input  fix_t ang,
  output logic done,
  output fix_t xo,
  output fix_t yo
);
  localparam int IW = $clog2(ITERS + 1);

  logic          busy;
  logic [IW-1:0] cnt;
  fix_t          z, dx, dy, da;

  assign dx = xo >>> cnt;
  assign dy = yo >>> cnt;
  assign da = atan_f(int'(cnt));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      done <= 1'b0;
      cnt  <= '0;
      xo   <= '0;
      yo   <= '0;
      z    <= '0;
    end else begin
      done <= 1'b0;
      if (go) begin
        xo   <= K_GAIN;
        yo   <= '0;
        z    <= ang;
        cnt  <= '0;
        busy <= 1'b1;
      end else if (busy) begin
        if (cnt == IW'(ITERS)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          if (z >= 0) begin
            xo <= xo - dy;
            yo <= yo + dx;
            z  <= z - da;
          end else begin
            xo <= xo + dy;
            yo <= yo - dx;
            z  <= z + da;
          end
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  AST_CORDIC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (xo >= -fix_t'(1024)) && (xo <= ONE_F + fix_t'(1024))
             && (yo >= -(ONE_F + fix_t'(1024))) && (yo <= ONE_F + fix_t'(1024))); // R5
endmodule

// File: rtl/scu_tofloat.sv
module scu_tofloat
  import scu_pkg::*;
(
  input  fix_t v,
  output fpv_t f
);
  logic [AW-1:0]    mag;
  logic [AW+15:0]   w;
  int               p;

  always_comb begin
    mag = v[AW-1] ? AW'(-v) : AW'(v);
    if (mag > AW'(ONE_F)) mag = AW'(ONE_F);
    p = 0;
    for (int i = 0; i < AW; i++) if (mag[i]) p = i;
    w = {16'b0, mag};
    if (p >= 15) w = w >> (p - 15);
    else         w = w << (15 - p);
    if (mag == '0) begin
      f = '0;
    end else begin
      f.cls  = CL_FIN;
      f.sgn  = v[AW-1];
      f.exp  = 8'(p - FRAC);
      f.mant = w[15:0];
    end
  end
endmodule

// File: rtl/sincos_unit.sv
module sincos_unit
  import scu_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int ITERS = 16,
  parameter int MAXE  = 63
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push_valid,
  output logic                         push_ready,
  input  logic [26:0]                  push_data,
  input  logic                         start,
  output logic                         busy,
  output logic                         done,
  output logic [$clog2(DEPTH+1)-1:0]   depth,
  output logic [26:0]                  st0,
  output logic [26:0]                  st1,
  output logic                         c2,
  output logic                         invalid_op,
  output logic                         stk_err
);
  localparam int DW = $clog2(DEPTH + 1);
  localparam int XW = $clog2(DEPTH);
  localparam logic [DW-1:0] FULL = DW'(DEPTH);

  typedef enum logic [1:0] {S_IDLE, S_RED, S_ROT} st_e;

  st_e           state;
  fpv_t          stk [DEPTH];
  logic [DW-1:0] cnt, cm1, cm2;
  fpv_t          op, s_res, c_res, sin_f, cos_f;
  logic          st_go, oor, red_go, red_done, cor_done, flip;
  logic          fin, wr, n_c2, n_inv, n_err;
  fix_t          ang, xo, yo, sin_v, cos_v;

  assign cm1   = cnt - 1'b1;
  assign cm2   = cnt - 2'd2;
  assign op    = (cnt != '0) ? stk[cm1[XW-1:0]] : '0;
  assign st0   = (cnt != '0) ? stk[cm1[XW-1:0]] : '0;
  assign st1   = (cnt > DW'(1)) ? stk[cm2[XW-1:0]] : '0;
  assign depth = cnt;
  assign busy  = (state != S_IDLE);
  assign st_go = start && (state == S_IDLE);
  assign push_ready = (state == S_IDLE) && !start && (cnt != FULL);
  assign oor   = (op.exp > 8'(MAXE)) || ((op.exp == 8'(MAXE)) && (op.mant != 16'h8000));
  assign red_go = st_go && (cnt != '0) && (op.cls == CL_FIN) && !oor;

  scu_reduce #(.MAXE(MAXE)) u_red (
    .clk(clk), .rst_n(rst_n), .go(red_go), .sgn(op.sgn), .exp(op.exp), .mant(op.mant),
    .done(red_done), .angle(ang), .flip(flip));

  scu_cordic #(.ITERS(ITERS)) u_cor (
    .clk(clk), .rst_n(rst_n), .go(red_done), .ang(ang), .done(cor_done), .xo(xo), .yo(yo));

  assign sin_v = flip ? -yo : yo;
  assign cos_v = flip ? -xo : xo;

  scu_tofloat u_fs (.v(sin_v), .f(sin_f));
  scu_tofloat u_fc (.v(cos_v), .f(cos_f));

  // completion decision and results
  always_comb begin
    fin = 1'b0; wr = 1'b0; n_c2 = 1'b0; n_inv = 1'b0; n_err = 1'b0;
    s_res = op; c_res = op;
    if (st_go) begin
      if (cnt == '0) begin
        fin = 1'b1; n_err = 1'b1;
      end else begin
        case (op.cls)
          CL_ZERO: begin fin = 1'b1; wr = 1'b1; c_res = ONE_V; end
          CL_INF:  begin fin = 1'b1; wr = 1'b1; n_inv = 1'b1; s_res = NAN_DEF; c_res = NAN_DEF; end
          CL_NAN:  begin fin = 1'b1; wr = 1'b1; end
          default: if (oor) begin fin = 1'b1; n_c2 = 1'b1; end
        endcase
      end
    end else if ((state == S_ROT) && cor_done) begin
      fin = 1'b1; wr = 1'b1; s_res = sin_f; c_res = cos_f;
    end
    if (wr && (cnt == FULL)) n_err = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      cnt        <= '0;
      done       <= 1'b0;
      c2         <= 1'b0;
      invalid_op <= 1'b0;
      stk_err    <= 1'b0;
    end else begin
      done <= fin;
      if (fin) begin
        c2         <= n_c2;
        invalid_op <= n_inv;
        stk_err    <= n_err;
        if (wr && (cnt != FULL)) begin
          stk[cm1[XW-1:0]] <= s_res;
          stk[cnt[XW-1:0]] <= c_res;
          cnt <= cnt + 1'b1;
        end
      end else if (push_valid && push_ready) begin
        stk[cnt[XW-1:0]] <= fpv_t'(push_data);
        cnt <= cnt + 1'b1;
      end
      case (state)
        S_IDLE:  if (red_go) state <= S_RED;
        S_RED:   if (red_done) state <= S_ROT;
        default: if (cor_done) state <= S_IDLE;
      endcase
    end
  end

  fpv_t st0_v;
  assign st0_v = fpv_t'(st0);

  AST_DEPTH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    done && !c2 && !stk_err |-> depth == $past(depth) + 1'b1); // R1
  AST_OOR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    done && c2 |-> $stable(depth) && $stable(st0)); // R2
  AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !(c2 && invalid_op)); // R3
  AST_RES_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    done && !c2 && !invalid_op && !stk_err && (st0_v.cls == CL_FIN) |-> st0_v.exp <= 8'sd0); // R5
  AST_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    done && stk_err |-> $stable(depth)); // R8
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R9
  AST_PUSH_GROW: assert property (@(posedge clk) disable iff (!rst_n)
    push_valid && push_ready |=> depth == $past(depth) + 1'b1); // R10
endmodule

// File: tb/sincos_unit_tb.sv
`timescale 1ns/1ps
module sincos_unit_tb;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        push_valid = 1'b0, start = 1'b0;
  logic [26:0] push_data = '0;
  logic        push_ready, busy, done, c2, invalid_op, stk_err;
  logic [3:0]  depth;
  logic [26:0] st0, st1;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  sincos_unit u_dut (
    .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_ready(push_ready),
    .push_data(push_data), .start(start), .busy(busy), .done(done), .depth(depth),
    .st0(st0), .st1(st1), .c2(c2), .invalid_op(invalid_op), .stk_err(stk_err));

  function automatic real pow2(input int n);
    real r = 1.0;
    if (n >= 0) for (int i = 0; i < n; i++) r = r * 2.0;
    else for (int i = 0; i < -n; i++) r = r / 2.0;
    return r;
  endfunction

  function automatic logic [26:0] enc(input real x);
    real a = (x < 0.0) ? -x : x;
    int  e = 0;
    while (a >= 2.0) begin a = a / 2.0; e++; end
    while (a < 1.0) begin a = a * 2.0; e--; end
    return {2'd1, (x < 0.0), 8'(e), 16'($rtoi(a * 32768.0))};
  endfunction

  function automatic real dec(input logic [26:0] v);
    real m;
    if (v[26:25] != 2'd1) return 0.0;
    m = real'(v[15:0]) * pow2(int'($signed(v[23:16])) - 15);
    return v[24] ? -m : m;
  endfunction

  task automatic chk_i(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_r(input string tag, input real act, input real exp);
    real d = act - exp;
    checks++;
    if (d > 0.0009765625 || d < -0.0009765625) begin
      errors++;
      $display("FAIL %s actual=%f expected=%f", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; start = 1'b0; push_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic push(input logic [26:0] v);
    push_data = v; push_valid = 1'b1;
    @(negedge clk);
    push_valid = 1'b0;
  endtask

  // pulses start and returns at the negedge where done is high
  task automatic run_op();
    int n = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done && n < 400) begin @(negedge clk); n++; end
    chk_i("R9 done seen", done, 1);
  endtask

  task automatic op_check(input real x);
    logic [26:0] v = enc(x);
    real xr = dec(v);
    do_reset();
    push(v);
    run_op();
    chk_i("R1 depth after op", depth, 2);
    chk_r("R5 sine on st1", dec(st1), $sin(xr));
    chk_r("R5 cosine on st0", dec(st0), $cos(xr));
    chk_i("R3 c2 cleared", c2, 0);
    @(negedge clk);
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [26:0] v, keep;
    int pulses;
    do_reset();
    // reset state
    chk_i("R10 reset depth", depth, 0);
    chk_i("R10 reset ready", push_ready, 1);
    chk_i("R9 reset busy", busy, 0);
    chk_i("R9 reset done", done, 0);
    chk_i("R3 reset flags", {c2, invalid_op, stk_err}, 0);

    // angle sweeps across all quadrants and several exponents
    for (int k = -80; k <= 80; k++) if (k != 0) op_check(real'(k) * 0.1931);
    for (int k = 1; k <= 18; k++) begin op_check(pow2(-k)); op_check(-pow2(-k) * 1.5); end
    op_check(1.5707963); op_check(-3.1415926); op_check(15.9);

    // signed zeros
    for (int s = 0; s < 2; s++) begin
      do_reset();
      push({2'd0, s[0], 24'd0});
      run_op();
      chk_i("R4 zero sine", st1, {2'd0, s[0], 24'd0});
      chk_i("R4 zero cosine", st0, {2'd1, 1'b0, 8'd0, 16'h8000});
      chk_i("R1 zero depth", depth, 2);
    end

    // infinities
    for (int s = 0; s < 2; s++) begin
      do_reset();
      push({2'd2, s[0], 24'd0});
      run_op();
      chk_i("R6 invalid flag", invalid_op, 1);
      chk_i("R6 sine default NaN", st1, {2'd3, 1'b1, 8'd0, 16'hC000});
      chk_i("R6 cosine default NaN", st0, {2'd3, 1'b1, 8'd0, 16'hC000});
      chk_i("R6 push occurs", depth, 2);
      @(negedge clk);
    end

    // NaN propagation
    do_reset();
    v = {2'd3, 1'b0, 8'd5, 16'hA123};
    push(v);
    run_op();
    chk_i("R7 sine NaN", st1, v);
    chk_i("R7 cosine NaN", st0, v);
    chk_i("R7 invalid low", invalid_op, 0);
    chk_i("R7 push occurs", depth, 2);

    // range boundary: exactly 2^63 accepted
    do_reset();
    push({2'd1, 1'b1, 8'd63, 16'h8000});
    run_op();
    chk_i("R2 boundary accepted", c2, 0);
    chk_i("R2 boundary depth", depth, 2);
    chk_i("R5 bound sine", (dec(st1) <= 1.0 && dec(st1) >= -1.0), 1);
    chk_i("R5 bound cosine", (dec(st0) <= 1.0 && dec(st0) >= -1.0), 1);

    // just above 2^63 and far above: rejected, then an in-range op clears c2
    for (int t = 0; t < 2; t++) begin
      do_reset();
      keep = (t == 0) ? {2'd1, 1'b0, 8'd63, 16'h8001} : {2'd1, 1'b1, 8'd100, 16'hC000};
      push(keep);
      run_op();
      chk_i("R2 c2 set", c2, 1);
      chk_i("R2 depth held", depth, 1);
      chk_i("R2 top held", st0, keep);
      chk_i("R3 no invalid on range", invalid_op, 0);
      @(negedge clk);
      push(enc(0.5));
      run_op();
      chk_i("R3 c2 cleared after accept", c2, 0);
      chk_r("R3 sine after reject", dec(st1), $sin(dec(enc(0.5))));
      @(negedge clk);
    end

    // full stack
    do_reset();
    for (int k = 0; k < 8; k++) push(enc(0.25 + real'(k)));
    chk_i("R10 ready low when full", push_ready, 0);
    keep = st0;
    run_op();
    chk_i("R8 overflow flag", stk_err, 1);
    chk_i("R8 depth held", depth, 8);
    chk_i("R8 top held", st0, keep);

    // empty stack
    do_reset();
    run_op();
    chk_i("R11 empty flag", stk_err, 1);
    chk_i("R11 depth stays zero", depth, 0);

    // busy behaviour and ignored start
    do_reset();
    push(enc(1.0));
    push(enc(2.0));
    chk_i("R10 push shows on top", st0, enc(2.0));
    chk_i("R10 push depth", depth, 2);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk_i("R9 busy after start", busy, 1);
    chk_i("R10 ready low while busy", push_ready, 0);
    start = 1'b1;
    push_valid = 1'b1; push_data = enc(3.0);
    @(negedge clk);
    start = 1'b0; push_valid = 1'b0;
    pulses = 0;
    for (int n = 0; n < 200; n++) begin
      if (done) pulses++;
      @(negedge clk);
    end
    chk_i("R9 single done pulse", pulses, 1);
    chk_i("R9 second start ignored depth", depth, 3);
    chk_i("R9 idle at end", busy, 0);
    chk_r("R1 sine below cosine", dec(st1), $sin(dec(enc(2.0))));

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule